// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block sits between a CPU's memory bus and two memory arrays: a 4 KB boot ROM and a 64 KB RAM. For each access it decides whether the current 16-bit address is served by the ROM or by the RAM. Three 2 KB windows can be overlaid by ROM: the bottom of the map, the window starting at 0xE800, and the top of the map. Whether the first two windows are overlaid depends on an 8-bit mode register. The top window is always ROM. Firmware uses this to boot from ROM, then switches the overlays off one by one so that RAM shows through.

The mode register sits behind an I/O write strobe. Each write to it changes exactly one of its bits. The low three data bits carry the one's complement of the bit number, and data bit 3 carries the one's complement of the value to store. One mode bit also gates the CPU interrupt request. All decoding is combinational from the address and the register as it stands before the clock edge. Writes that hit a ROM-overlaid window are dropped. The whole register can be observed on a debug output.

Top module: `rom_overlay_decoder`

## Requirements
- R1: While reset is asserted, and on leaving reset, all eight bits of the mode register are 0.
- R2: A mode-register write with data `d` sets bit number `~d[2:0]` to the value `~d[3]` and leaves the other seven bits unchanged. Example: 0x04 sets bit 3 to 1, 0x0C clears bit 3, 0x02 sets bit 5, 0x05 sets bit 2. With the mode-register strobe low, the register holds its value.
- R3: Addresses 0x0000–0x07FF select ROM only while mode bits 3 and 5 are both 0. Otherwise they select RAM.
- R4: Addresses 0xE800–0xEFFF select ROM while mode bit 3 is 0. Otherwise they select RAM.
- R5: Addresses 0xF800–0xFFFF select ROM for any mode register value.
- R6: Every other address selects RAM, with `ram_addr` equal to the CPU address.
- R7: `rom_addr` is a 12-bit value. Its bits 10:0 are CPU address bits 10:0, and its bit 11 is CPU address bit 12.
- R8: A write to a window that currently selects ROM asserts neither `ram_we`, `ram_sel` nor `rom_sel`. A write anywhere else asserts `ram_we` and `ram_sel`.
- R9: `irq_out` is 1 exactly when `irq_raw` is 1 and mode bit 2 is 1.
- R10: A mode-register write that happens in the same cycle as a memory access does not affect that access. The new mode applies from the cycle after the clock edge.
- R11: With neither read nor write strobe active, `rom_sel`, `ram_sel` and `ram_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | Mode-register write strobe |
| wdata | input | 8 | Write data for the mode register |
| irq_raw | input | 1 | Raw interrupt request |
| rom_sel | output | 1 | ROM chip select (read only) |
| rom_addr | output | 12 | Folded ROM address |
| ram_sel | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| irq_out | output | 1 | Gated interrupt to the CPU |
| ctl_dbg | output | 8 | Current mode register contents |

## Verification
A mode-register write and a memory access can fall in the same cycle. The bench sets up this collision on purpose. Mode bit 3 is set, 0xE800 is presented for a read, and in that same cycle a write that clears bit 3 is issued. Before the edge the access must still go to RAM. After the edge the same address must go to ROM. The reverse case, which turns the overlay off under a live access, is judged the same way.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ADDR_W   = 16;
  localparam int CTL_W    = 8;
  localparam int IDX_W    = $clog2(CTL_W);
  localparam int WIN_AW   = 11;
  localparam int TAG_W    = ADDR_W - WIN_AW;
  localparam int ROM_AW   = WIN_AW + 1;
  localparam int FOLD_BIT = 12;
  localparam int NUM_WIN  = 3;
  localparam int IRQ_BIT  = 2;

  typedef logic [CTL_W-1:0] ctl_t;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    ctl_t             block_mask;
  } win_cfg_t;

  // overlay windows: tag of the 2 KB slot and the mode bits that turn it off
  function automatic win_cfg_t win_cfg(input int idx);
    win_cfg_t c;
    case (idx)
      0:       begin c.tag = 5'h00; c.block_mask = 8'h28; end
      1:       begin c.tag = 5'h1D; c.block_mask = 8'h08; end
      default: begin c.tag = 5'h1F; c.block_mask = 8'h00; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ovl_ctl_latch.sv
module ovl_ctl_latch
  import ovl_pkg::*;
#(
  parameter int W  = CTL_W,
  parameter int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [IW:0]  wr_code,
  output logic [W-1:0] ctl_q
);
  logic [W-1:0]  ctl_d;
  logic [IW-1:0] bit_idx;
  logic          bit_val;

  assign bit_idx = ~wr_code[IW-1:0];
  assign bit_val = ~wr_code[IW];

  always_comb begin
    ctl_d = ctl_q;
    for (int i = 0; i < W; i++) begin
      if (bit_idx == IW'(i)) ctl_d[i] = bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/ovl_window_decode.sv
module ovl_window_decode
  import ovl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NUM_WIN
) (
  input  logic [AW-1:0] addr,
  input  ctl_t          ctl,
  output logic          in_rom
);
  localparam int TW = AW - WIN_AW;
  logic [NW-1:0] hit;

  generate
    for (genvar w = 0; w < NW; w++) begin : g_win
      localparam win_cfg_t CFG = win_cfg(w);
      logic tag_match;
      logic enabled;
      assign tag_match = (addr[AW-1:WIN_AW] == TW'(CFG.tag));
      assign enabled   = ((ctl & CFG.block_mask) == '0);
      assign hit[w]    = tag_match & enabled;
    end
  endgenerate

  assign in_rom = |hit;
endmodule

// File: rtl/ovl_rom_fold.sv
module ovl_rom_fold
  import ovl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = ROM_AW,
  parameter int FB = FOLD_BIT
) (
  input  logic [AW-1:0] addr,
  output logic [RW-1:0] rom_addr
);
  assign rom_addr = {addr[FB], addr[RW-2:0]};
endmodule

// File: rtl/rom_overlay_decoder.sv
module rom_overlay_decoder
  import ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [CTL_W-1:0]  wdata,
  input  logic              irq_raw,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              irq_out,
  output logic [CTL_W-1:0]  ctl_dbg
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  ctl_t       ctl_q;
  logic       in_rom;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ovl_ctl_latch #(.W(CTL_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (io_wr),
    .wr_code (wdata[IDX_W:0]),
    .ctl_q   (ctl_q)
  );

  ovl_window_decode #(.AW(ADDR_W), .NW(NUM_WIN)) u_dec (
    .addr   (cpu_addr),
    .ctl    (ctl_q),
    .in_rom (in_rom)
  );

  ovl_rom_fold #(.AW(ADDR_W), .RW(ROM_AW), .FB(FOLD_BIT)) u_fold (
    .addr     (cpu_addr),
    .rom_addr (rom_addr)
  );

  assign rom_sel  = mem_rd & in_rom;
  assign ram_we   = mem_wr & ~in_rom;
  assign ram_sel  = (mem_rd & ~in_rom) | ram_we;
  assign ram_addr = cpu_addr;
  assign irq_out  = irq_raw & ctl_q[IRQ_BIT];
  assign ctl_dbg  = ctl_q;
endmodule

// File: rtl/ovl_decoder_chk.sv
module ovl_decoder_chk
  import ovl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_wr,
  input logic              irq_raw,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic              ram_we,
  input logic              irq_out,
  input logic [CTL_W-1:0]  ctl_dbg
);
  // R2
  ctl_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> ($countones(ctl_dbg ^ $past(ctl_dbg)) <= 1));

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(ctl_dbg));

  // R5
  top_window_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cpu_addr[15:11] == 5'h1F) |-> (rom_sel && !ram_sel));

  // R3
  low_window_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cpu_addr[15:11] == 5'h00 && ctl_dbg[5]) |-> (ram_sel && !rom_sel));

  // R4
  mid_window_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cpu_addr[15:11] == 5'h1D && !ctl_dbg[3]) |-> !ram_we);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (irq_raw && ctl_dbg[2]));

  // R11
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> (!rom_sel && !ram_sel && !ram_we));
endmodule

bind rom_overlay_decoder ovl_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .io_wr    (io_wr),
  .irq_raw  (irq_raw),
  .rom_sel  (rom_sel),
  .ram_sel  (ram_sel),
  .ram_we   (ram_we),
  .irq_out  (irq_out),
  .ctl_dbg  (ctl_dbg)
);

// File: tb/rom_overlay_decoder_bench.sv
module rom_overlay_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mem_rd, mem_wr, io_wr, irq_raw;
  logic [7:0]  wdata;
  logic        rom_sel, ram_sel, ram_we, irq_out;
  logic [11:0] rom_addr;
  logic [15:0] ram_addr;
  logic [7:0]  ctl_dbg;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rom_overlay_decoder u_rom_overlay_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_wr(io_wr), .wdata(wdata), .irq_raw(irq_raw),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_sel(ram_sel),
    .ram_we(ram_we), .ram_addr(ram_addr), .irq_out(irq_out),
    .ctl_dbg(ctl_dbg)
  );

  // vector: addr[16] rd wr | rom_sel ram_sel ram_we | rom_addr[12]  (mode = 0)
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {16'h0123, 2'b10, 3'b100, 12'h123},  // R3 low window read
    {16'h07FF, 2'b10, 3'b100, 12'h7FF},  // R3 edge
    {16'h0800, 2'b10, 3'b010, 12'h000},  // R6 just past low window
    {16'h0456, 2'b01, 3'b000, 12'h456},  // R8 write dropped
    {16'hE800, 2'b10, 3'b100, 12'h000},  // R4
    {16'hEFFF, 2'b10, 3'b100, 12'h7FF},  // R4 edge
    {16'hF800, 2'b10, 3'b100, 12'h800},  // R5 R7
    {16'hFFFF, 2'b01, 3'b000, 12'hFFF},  // R5 R8
    {16'hF7FF, 2'b10, 3'b010, 12'hFFF},  // R6
    {16'hE7FF, 2'b01, 3'b011, 12'h7FF},  // R6 R8
    {16'h1234, 2'b01, 3'b011, 12'hA34},  // R7 R8
    {16'h8000, 2'b00, 3'b000, 12'h000},  // R11
    {16'h5ABC, 2'b10, 3'b010, 12'hABC}   // R6 R7
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] code(input int idx, input bit val);
    return {4'h0, ~val, ~3'(idx)};
  endfunction

  task automatic mode_write(input int idx, input bit val);
    @(negedge clk);
    io_wr = 1'b1; wdata = code(idx, val);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input bit rd, input bit wr);
    @(negedge clk);
    cpu_addr = a; mem_rd = rd; mem_wr = wr;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_ctl;
    rst_n = 1'b0; cpu_addr = '0; mem_rd = 0; mem_wr = 0; io_wr = 0;
    wdata = '0; irq_raw = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R1 reset mode", ctl_dbg, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", ctl_dbg, 8'h00);
    check("R9 irq gated off", irq_out, 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][32:17], VEC[i][16], VEC[i][15]);
      check($sformatf("R3-6/R8/R11 vec%0d rom_sel", i), rom_sel, VEC[i][14]);
      check($sformatf("R6/R8 vec%0d ram_sel", i), ram_sel, VEC[i][13]);
      check($sformatf("R8 vec%0d ram_we", i), ram_we, VEC[i][12]);
      check($sformatf("R7 vec%0d rom_addr", i), rom_addr, VEC[i][11:0]);
      if (VEC[i][13]) check($sformatf("R6 vec%0d ram_addr", i), ram_addr, VEC[i][32:17]);
    end
    access(16'h0000, 0, 0);

    // R2: walk each bit set then clear
    exp_ctl = 8'h00;
    for (int b = 0; b < 8; b++) begin
      mode_write(b, 1'b1);
      exp_ctl[b] = 1'b1;
      check($sformatf("R2 set bit%0d", b), ctl_dbg, exp_ctl);
    end
    mode_write(4, 1'b0); exp_ctl[4] = 1'b0;
    check("R2 clear bit4", ctl_dbg, exp_ctl);
    @(negedge clk); wdata = 8'h0F; #1;
    @(negedge clk);
    check("R2 hold without strobe", ctl_dbg, exp_ctl);
    for (int b = 0; b < 8; b++) mode_write(b, 1'b0);
    check("R2 all cleared", ctl_dbg, 8'h00);

    // R9
    irq_raw = 1'b1; mode_write(2, 1'b1);
    check("R9 irq passes", irq_out, 1'b1);
    irq_raw = 1'b0; #1;
    check("R9 raw low", irq_out, 1'b0);
    mode_write(2, 1'b0);

    // R3: bit5 alone disables low window, leaves mid window
    mode_write(5, 1'b1);
    access(16'h0100, 1, 0);
    check("R3 bit5 low->ram", {rom_sel, ram_sel}, 2'b01);
    access(16'h0100, 0, 1);
    check("R3 bit5 write lands", ram_we, 1'b1);
    access(16'hE900, 1, 0);
    check("R4 bit5 mid still rom", rom_sel, 1'b1);
    mode_write(5, 1'b0);

    // R3/R4/R5 with bit3
    mode_write(3, 1'b1);
    access(16'h0100, 1, 0);
    check("R3 bit3 low->ram", {rom_sel, ram_sel}, 2'b01);
    access(16'hE900, 1, 0);
    check("R4 bit3 mid->ram", {rom_sel, ram_sel}, 2'b01);
    access(16'hFA00, 0, 1);
    check("R5 top write dropped", {ram_we, ram_sel}, 2'b00);
    access(16'hFA00, 1, 0);
    check("R5 top rom", rom_sel, 1'b1);

    // R10: mode write colliding with access
    access(16'hE800, 1, 0);
    io_wr = 1'b1; wdata = code(3, 1'b0); #1;
    check("R10 old mode same cycle", {rom_sel, ram_sel}, 2'b01);
    @(negedge clk); io_wr = 1'b0; #1;
    check("R10 new mode next cycle", {rom_sel, ram_sel}, 2'b10);
    access(16'hE800, 0, 1);
    io_wr = 1'b1; wdata = code(3, 1'b1); #1;
    check("R10 write still dropped", ram_we, 1'b0);
    @(negedge clk); io_wr = 1'b0; #1;
    check("R10 write lands after", ram_we, 1'b1);

    // R1: reset mid-run
    mode_write(6, 1'b1);
    access(16'h0000, 0, 0);
    rst_n = 1'b0; #1;
    check("R1 async clear", ctl_dbg, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(16'h0010, 1, 0);
    check("R1 overlays back", rom_sel, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule